// File: doc/BRIEF.md
# Event-Driven Power-Gating Task Scheduler

This block decides when each hardware micro-task of a sensor node is switched on. Incoming event pulses, whether from outside or from tasks that have just finished, are caught in one-bit registers that hold until a task consumes them. A guard per task looks at those registers. A guard either needs every event in its set (all-mode) or any one of them (any-mode). When a guard is met and no running task could write a resource the candidate touches, the task's power enable is set. The enable stays high until the task reports that it is done. On that same edge the task's output events are posted back into the event registers.

Each local memory bank has its own power enable. That enable is high exactly while at least one task mapped to the bank is powered. A hold input stops any new activation while events keep being caught. Once running tasks drain, every task and memory enable is low and only the scheduler remains on. Guards, resource use and write sets, the task-to-bank map and the events each task raises are all elaboration-time parameters.

Top module: `pwr_task_sched`

## Requirements
- R1: An event pulse sets its event register on the next clock edge. The register stays set until a granted task consumes it. `ev_ack_o` pulses for one cycle, in the first cycle of the new task enable, with a 1 at each consumed event bit (bit k = event k).
- R2: An all-mode guard grants only when every event in its mask is latched. An any-mode guard grants when at least one event in its mask is latched. In the defaults, task 1 needs events 1 and 2, and task 2 needs event 3 or event 4.
- R3: A task enable rises on the second clock edge after the event pulse that completes its guard is sampled. It stays high until `task_done_i` for that task is sampled. A done pulse for a task that is not enabled has no effect.
- R4: When a done pulse ends a task, the events in that task's raise mask are set on the same edge. In the defaults, task 0 raises event 2, task 1 raises event 3, and task 2 raises event 5.
- R5: Two tasks where one writes a resource the other uses are never enabled together. A candidate waits while a conflicting task is enabled. In the defaults, task 0 writes resource 0 and task 2 reads it.
- R6: When conflicting candidates become eligible in the same cycle, the lowest-indexed task is granted. The others stay pending with their events latched and are granted once the winner has finished.
- R7: If an event pulse arrives in the same cycle that a grant clears that event, the event stays set.
- R8: A memory enable is high in exactly the cycles where at least one task mapped to that bank is enabled. It rises together with the first such task enable and falls when the last such task finishes. In the defaults, bank 0 serves tasks 0 and 3, and bank 1 serves tasks 1 and 2.
- R9: While `hold_i` is high, no task is newly enabled and events still latch. Running tasks continue until done. With no task running, all task and memory enables are low.
- R10: A synchronous reset clears all event registers, task enables, memory enables and acknowledgements.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| hold_i | input | 1 | Block new activations (deep low-power request) |
| ev_pulse_i | input | N_EV | External event pulses, one bit per event |
| task_done_i | input | N_TASK | Task termination pulses, one bit per task |
| task_en_o | output | N_TASK | Per-task power enable |
| mem_en_o | output | N_MEM | Per-bank memory power enable |
| ev_ack_o | output | N_EV | One-cycle mask of events consumed by a new grant |

## Verification
A single event on an all-mode guard must leave the task off, and the missing event must then start it. This tells all-mode apart from any-mode, and any-mode is tried with a lone event. Simultaneous events for two conflicting tasks tell priority apart from parallel start. Simultaneous events for two independent tasks that share a bank show concurrency and show that the bank stays on until the last user is done. A re-pulse on the grant edge, a spurious done, a held request and a chained run with fixed-latency responders each isolate set-wins, done filtering, hold gating and raised-event sequencing.

// File: rtl/sched_pkg.sv
package sched_pkg;
   typedef enum logic {
      GUARD_ALL = 1'b0,
      GUARD_ANY = 1'b1
   } guard_mode_e;

   localparam int SCHED_MAX_TASKS  = 32;
   localparam int SCHED_MAX_EVENTS = 64;
endpackage

// File: rtl/sched_event_bank.sv
module sched_event_bank #(
   parameter int N_EV = 6
) (
   input  logic            clk,
   input  logic            rst,
   input  logic [N_EV-1:0] set_i,
   input  logic [N_EV-1:0] clr_i,
   output logic [N_EV-1:0] ev_o,
   output logic [N_EV-1:0] ack_o
);
   logic [N_EV-1:0] ev_q;
   logic [N_EV-1:0] ack_q;

   // set has priority over clear so a fresh pulse is never lost
   always_ff @(posedge clk) begin
      if (rst) begin
         ev_q  <= '0;
         ack_q <= '0;
      end else begin
         ev_q  <= (ev_q & ~clr_i) | set_i;
         ack_q <= clr_i & ev_q;
      end
   end

   assign ev_o  = ev_q;
   assign ack_o = ack_q;

   for (genvar e = 0; e < N_EV; e++) begin : g_chk
      assert_set_wins_R7: assert property (@(posedge clk) disable iff (rst)
         set_i[e] |=> ev_o[e]);
   end
endmodule

// File: rtl/sched_guard_arbiter.sv
module sched_guard_arbiter
   import sched_pkg::*;
#(
   parameter int                        N_EV       = 6,
   parameter int                        N_TASK     = 4,
   parameter int                        N_RES      = 3,
   parameter logic [N_TASK*N_EV-1:0]    GUARD_MASK = '1,
   parameter logic [N_TASK-1:0]         GUARD_MODE = '0,
   parameter logic [N_TASK*N_RES-1:0]   RES_USE    = '0,
   parameter logic [N_TASK*N_RES-1:0]   RES_WR     = '0
) (
   input  logic [N_EV-1:0]   ev_i,
   input  logic [N_TASK-1:0] active_i,
   input  logic              hold_i,
   output logic [N_TASK-1:0] grant_o,
   output logic [N_EV-1:0]   consume_o
);
   localparam int PAIRS = N_TASK * N_TASK;

   logic [N_TASK-1:0] guard_ok;
   logic [N_TASK-1:0] ready;
   logic [PAIRS-1:0]  blk_res;
   logic [PAIRS-1:0]  blk_ev;

   for (genvar t = 0; t < N_TASK; t++) begin : g_guard
      localparam logic [N_EV-1:0] M = GUARD_MASK[t*N_EV +: N_EV];
      if (guard_mode_e'(GUARD_MODE[t]) == GUARD_ANY) begin : g_any
         assign guard_ok[t] = |(ev_i & M);
      end else begin : g_all
         assign guard_ok[t] = ((ev_i & M) == M);
      end
   end

   for (genvar i = 0; i < N_TASK; i++) begin : g_row
      for (genvar j = 0; j < N_TASK; j++) begin : g_col
         localparam logic [N_RES-1:0] UI = RES_USE[i*N_RES +: N_RES];
         localparam logic [N_RES-1:0] WI = RES_WR[i*N_RES +: N_RES];
         localparam logic [N_RES-1:0] UJ = RES_USE[j*N_RES +: N_RES];
         localparam logic [N_RES-1:0] WJ = RES_WR[j*N_RES +: N_RES];
         localparam logic [N_EV-1:0]  GI = GUARD_MASK[i*N_EV +: N_EV];
         localparam logic [N_EV-1:0]  GJ = GUARD_MASK[j*N_EV +: N_EV];
         if (i == j) begin : g_self
            assign blk_res[i*N_TASK+j] = 1'b0;
            assign blk_ev[i*N_TASK+j]  = 1'b0;
         end else begin : g_pair
            assign blk_res[i*N_TASK+j] = (|(WI & (UJ | WJ))) || (|(WJ & (UI | WI)));
            assign blk_ev[i*N_TASK+j]  = |(GI & GJ);
         end
      end
   end

   assign ready = guard_ok & ~active_i & {N_TASK{~hold_i}};

   // ascending scan: a lower index claims resources and events first
   always_comb begin
      grant_o   = '0;
      consume_o = '0;
      for (int i = 0; i < N_TASK; i++) begin
         if (ready[i]
             && !(|(blk_res[i*N_TASK +: N_TASK] & (active_i | grant_o)))
             && !(|(blk_ev[i*N_TASK +: N_TASK] & grant_o))) begin
            grant_o[i] = 1'b1;
            consume_o  = consume_o | GUARD_MASK[i*N_EV +: N_EV];
         end
      end
   end
endmodule

// File: rtl/sched_mem_gate.sv
module sched_mem_gate #(
   parameter int                       N_TASK   = 4,
   parameter int                       N_MEM    = 2,
   parameter logic [N_TASK*N_MEM-1:0]  TASK_MEM = '0
) (
   input  logic              clk,
   input  logic              rst,
   input  logic [N_TASK-1:0] status_next_i,
   output logic [N_MEM-1:0]  mem_en_o
);
   logic [N_MEM-1:0] mem_q;

   for (genvar m = 0; m < N_MEM; m++) begin : g_bank
      logic [N_TASK-1:0] users;
      for (genvar t = 0; t < N_TASK; t++) begin : g_user
         assign users[t] = TASK_MEM[t*N_MEM + m];
      end
      always_ff @(posedge clk) begin
         if (rst) mem_q[m] <= 1'b0;
         else     mem_q[m] <= |(status_next_i & users);
      end
   end

   assign mem_en_o = mem_q;
endmodule

// File: rtl/pwr_task_sched.sv
module pwr_task_sched
   import sched_pkg::*;
#(
   parameter int                        N_EV       = 6,
   parameter int                        N_TASK     = 4,
   parameter int                        N_MEM      = 2,
   parameter int                        N_RES      = 3,
   parameter logic [N_TASK*N_EV-1:0]    GUARD_MASK = 24'b100000_011000_000110_000001,
   parameter logic [N_TASK-1:0]         GUARD_MODE = 4'b0100,
   parameter logic [N_TASK*N_RES-1:0]   RES_USE    = 12'b100_001_010_001,
   parameter logic [N_TASK*N_RES-1:0]   RES_WR     = 12'b100_000_010_001,
   parameter logic [N_TASK*N_MEM-1:0]   TASK_MEM   = 8'b01_10_10_01,
   parameter logic [N_TASK*N_EV-1:0]    TASK_RAISE = 24'b000000_100000_001000_000100
) (
   input  logic              clk,
   input  logic              rst,
   input  logic              hold_i,
   input  logic [N_EV-1:0]   ev_pulse_i,
   input  logic [N_TASK-1:0] task_done_i,
   output logic [N_TASK-1:0] task_en_o,
   output logic [N_MEM-1:0]  mem_en_o,
   output logic [N_EV-1:0]   ev_ack_o
);
   if (N_EV < 1 || N_EV > SCHED_MAX_EVENTS) begin : g_bad_ev
      $error("pwr_task_sched: N_EV out of range");
   end
   if (N_TASK < 1 || N_TASK > SCHED_MAX_TASKS) begin : g_bad_task
      $error("pwr_task_sched: N_TASK out of range");
   end
   if (N_MEM < 1 || N_RES < 1) begin : g_bad_mem
      $error("pwr_task_sched: N_MEM and N_RES must be positive");
   end
   for (genvar t = 0; t < N_TASK; t++) begin : g_guard_chk
      if (GUARD_MASK[t*N_EV +: N_EV] == '0) begin : g_empty
         $error("pwr_task_sched: a task guard references no event");
      end
   end

   logic [N_TASK-1:0] status_q;
   logic [N_TASK-1:0] status_next;
   logic [N_TASK-1:0] grant;
   logic [N_EV-1:0]   ev_q;
   logic [N_EV-1:0]   consume;
   logic [N_EV-1:0]   raise;
   logic [N_TASK-1:0] finishing;

   assign finishing = task_done_i & status_q;

   always_comb begin
      raise = '0;
      for (int t = 0; t < N_TASK; t++) begin
         if (finishing[t]) raise = raise | TASK_RAISE[t*N_EV +: N_EV];
      end
   end

   sched_event_bank #(.N_EV(N_EV)) u_events (
      .clk   (clk),
      .rst   (rst),
      .set_i (ev_pulse_i | raise),
      .clr_i (consume),
      .ev_o  (ev_q),
      .ack_o (ev_ack_o)
   );

   sched_guard_arbiter #(
      .N_EV       (N_EV),
      .N_TASK     (N_TASK),
      .N_RES      (N_RES),
      .GUARD_MASK (GUARD_MASK),
      .GUARD_MODE (GUARD_MODE),
      .RES_USE    (RES_USE),
      .RES_WR     (RES_WR)
   ) u_arb (
      .ev_i      (ev_q),
      .active_i  (status_q),
      .hold_i    (hold_i),
      .grant_o   (grant),
      .consume_o (consume)
   );

   assign status_next = (status_q & ~finishing) | grant;

   always_ff @(posedge clk) begin
      if (rst) status_q <= '0;
      else     status_q <= status_next;
   end

   sched_mem_gate #(
      .N_TASK   (N_TASK),
      .N_MEM    (N_MEM),
      .TASK_MEM (TASK_MEM)
   ) u_mem (
      .clk           (clk),
      .rst           (rst),
      .status_next_i (status_next),
      .mem_en_o      (mem_en_o)
   );

   assign task_en_o = status_q;

   for (genvar t = 0; t < N_TASK; t++) begin : g_task_chk
      localparam logic [N_EV-1:0] GM = GUARD_MASK[t*N_EV +: N_EV];
      assert_run_to_done_R3: assert property (@(posedge clk) disable iff (rst)
         (task_en_o[t] && !task_done_i[t]) |=> task_en_o[t]);
      assert_hold_blocks_R9: assert property (@(posedge clk) disable iff (rst)
         (hold_i && !task_en_o[t]) |=> !task_en_o[t]);
      if (guard_mode_e'(GUARD_MODE[t]) == GUARD_ALL) begin : g_all_chk
         assert_guard_consumed_R2: assert property (@(posedge clk) disable iff (rst)
            $rose(task_en_o[t]) |-> ((ev_ack_o & GM) == GM));
      end else begin : g_any_chk
         assert_guard_consumed_R1: assert property (@(posedge clk) disable iff (rst)
            $rose(task_en_o[t]) |-> (|(ev_ack_o & GM)));
      end
      for (genvar u = t + 1; u < N_TASK; u++) begin : g_pair_chk
         localparam logic [N_RES-1:0] UT = RES_USE[t*N_RES +: N_RES];
         localparam logic [N_RES-1:0] WT = RES_WR[t*N_RES +: N_RES];
         localparam logic [N_RES-1:0] UU = RES_USE[u*N_RES +: N_RES];
         localparam logic [N_RES-1:0] WU = RES_WR[u*N_RES +: N_RES];
         if ((|(WT & (UU | WU))) || (|(WU & (UT | WT)))) begin : g_conf
            assert_no_conflict_R5: assert property (@(posedge clk) disable iff (rst)
               !(task_en_o[t] && task_en_o[u]));
         end
      end
   end

   for (genvar m = 0; m < N_MEM; m++) begin : g_mem_chk
      logic [N_TASK-1:0] users;
      for (genvar t = 0; t < N_TASK; t++) begin : g_u
         assign users[t] = TASK_MEM[t*N_MEM + m];
      end
      assert_mem_follows_R8: assert property (@(posedge clk) disable iff (rst)
         mem_en_o[m] == (|(task_en_o & users)));
   end
endmodule

// File: tb/pwr_task_sched_tb_top.sv
`timescale 1ns/100ps
module pwr_task_sched_tb_top;
   localparam int LAT = 3;

   logic       clk = 1'b0;
   logic       rst = 1'b1;
   logic       hold = 1'b0;
   logic [5:0] ev = '0;
   logic [3:0] done = '0;
   logic [3:0] task_en;
   logic [1:0] mem_en;
   logic [5:0] ack;

   int checks = 0;
   int errors = 0;

   always #2.5 clk = ~clk;

   pwr_task_sched dut_i (
      .clk         (clk),
      .rst         (rst),
      .hold_i      (hold),
      .ev_pulse_i  (ev),
      .task_done_i (done),
      .task_en_o   (task_en),
      .mem_en_o    (mem_en),
      .ev_ack_o    (ack)
   );

   task automatic step();
      @(negedge clk);
   endtask

   task automatic chk(input string req, input string what,
                      input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
      end
   endtask

   task automatic reset_dut();
      rst = 1'b1; hold = 1'b0; ev = '0; done = '0;
      step(); step();
      rst = 1'b0;
   endtask

   task automatic pulse(input logic [5:0] m);
      ev = m; step(); ev = '0;
   endtask

   task automatic finish_task(input int t);
      done = 4'(1 << t); step(); done = '0;
   endtask

   task automatic test_reset();
      reset_dut();
      chk("R10", "task_en after reset", 32'(task_en), 0);
      chk("R10", "mem_en after reset", 32'(mem_en), 0);
      chk("R10", "ack after reset", 32'(ack), 0);
      pulse(6'b000001); step();
      chk("R3", "task0 on two edges after pulse", 32'(task_en), 32'b0001);
      rst = 1'b1; step(); rst = 1'b0;
      chk("R10", "task_en cleared by reset", 32'(task_en), 0);
      chk("R10", "mem_en cleared by reset", 32'(mem_en), 0);
      step(); step();
      chk("R10", "event cleared by reset", 32'(task_en), 0);
   endtask

   task automatic test_all_guard();
      reset_dut();
      pulse(6'b000010); step(); step();
      chk("R2", "all-mode guard with one event", 32'(task_en), 0);
      pulse(6'b000100); step();
      chk("R2", "all-mode guard complete", 32'(task_en), 32'b0010);
      chk("R1", "ack of consumed events", 32'(ack), 32'b000110);
      chk("R8", "bank1 on with task1", 32'(mem_en), 32'b10);
      step();
      chk("R1", "ack lasts one cycle", 32'(ack), 0);
      chk("R3", "task stays on until done", 32'(task_en), 32'b0010);
      finish_task(1);
      chk("R3", "task off after done", 32'(task_en), 0);
      chk("R8", "bank1 off with no user", 32'(mem_en), 0);
      step();
      chk("R4", "raised event starts task2", 32'(task_en), 32'b0100);
      chk("R4", "raised event consumed", 32'(ack), 32'b001000);
   endtask

   task automatic test_any_guard();
      reset_dut();
      pulse(6'b010000); step();
      chk("R2", "any-mode guard with one event", 32'(task_en), 32'b0100);
      chk("R1", "ack for any-mode", 32'(ack), 32'b010000);
      finish_task(2);
      chk("R3", "task2 off", 32'(task_en), 0);
      step();
      chk("R4", "task2 raise starts task3", 32'(task_en), 32'b1000);
      chk("R8", "bank0 with task3", 32'(mem_en), 32'b01);
   endtask

   task automatic test_conflict();
      reset_dut();
      pulse(6'b010001); step();
      chk("R6", "lowest index wins", 32'(task_en), 32'b0001);
      chk("R6", "loser events not consumed", 32'(ack), 32'b000001);
      step(); step();
      chk("R5", "conflicting task kept off", 32'(task_en), 32'b0001);
      finish_task(0);
      chk("R5", "no overlap at handover", 32'(task_en), 0);
      step();
      chk("R6", "pending task granted later", 32'(task_en), 32'b0100);
      chk("R6", "pending event still latched", 32'(ack), 32'b010000);
      pulse(6'b000010); step();
      chk("R1", "raised event held until used", 32'(task_en), 32'b0110);
      chk("R1", "ack of held event", 32'(ack), 32'b000110);
      chk("R8", "bank1 shared on", 32'(mem_en), 32'b10);
   endtask

   task automatic test_parallel_mem();
      reset_dut();
      pulse(6'b100001); step();
      chk("R5", "independent tasks together", 32'(task_en), 32'b1001);
      chk("R8", "shared bank on", 32'(mem_en), 32'b01);
      finish_task(0);
      chk("R8", "bank stays on for other user", 32'(mem_en), 32'b01);
      chk("R3", "only task0 ended", 32'(task_en), 32'b1000);
      finish_task(3);
      chk("R8", "bank off after last user", 32'(mem_en), 0);
   endtask

   task automatic test_set_wins();
      reset_dut();
      ev = 6'b000001; step(); step(); ev = '0;
      chk("R7", "task0 granted", 32'(task_en), 32'b0001);
      finish_task(0);
      chk("R7", "task0 ended", 32'(task_en), 0);
      step();
      chk("R7", "re-pulsed event kept", 32'(task_en), 32'b0001);
      chk("R7", "second consume ack", 32'(ack), 32'b000001);
   endtask

   task automatic test_hold();
      reset_dut();
      hold = 1'b1;
      pulse(6'b000001); step(); step();
      chk("R9", "no grant while held", 32'(task_en), 0);
      chk("R9", "banks off while held", 32'(mem_en), 0);
      hold = 1'b0; step();
      chk("R9", "latched event granted after hold", 32'(task_en), 32'b0001);
      hold = 1'b1; step(); step();
      chk("R9", "running task continues under hold", 32'(task_en), 32'b0001);
      finish_task(0);
      chk("R9", "all task enables low", 32'(task_en), 0);
      chk("R9", "all bank enables low", 32'(mem_en), 0);
      hold = 1'b0;
   endtask

   task automatic test_spurious_done();
      reset_dut();
      finish_task(0);
      pulse(6'b000010); step(); step();
      chk("R3", "done while idle raises nothing", 32'(task_en), 0);
      chk("R3", "idle done leaves banks off", 32'(mem_en), 0);
   endtask

   task automatic test_chain();
      int order[8];
      int n = 0;
      int overlap = 0;
      int cnt[4] = '{0, 0, 0, 0};
      logic [3:0] prev = '0;
      reset_dut();
      pulse(6'b000011);
      for (int c = 0; c < 60; c++) begin
         for (int i = 0; i < 4; i++) begin
            if (task_en[i] && !prev[i]) begin
               if (n < 8) order[n] = i;
               n++;
            end
            done[i] = 1'b0;
            if (task_en[i]) begin
               cnt[i]++;
               if (cnt[i] == LAT) begin
                  done[i] = 1'b1;
                  cnt[i] = 0;
               end
            end
         end
         if (task_en[0] && task_en[2]) overlap++;
         prev = task_en;
         step();
      end
      done = '0;
      chk("R4", "tasks started in chain", 32'(n), 4);
      for (int k = 0; k < 4; k++) begin
         if (k < n) chk("R4", "chain order", 32'(order[k]), 32'(k));
      end
      chk("R5", "no conflicting overlap", 32'(overlap), 0);
      chk("R9", "idle after chain", 32'(task_en), 0);
      chk("R8", "banks off after chain", 32'(mem_en), 0);
   endtask

   initial begin
      repeat (20000) @(posedge clk);
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

   initial begin
      test_reset();
      test_all_guard();
      test_any_guard();
      test_conflict();
      test_parallel_mem();
      test_set_wins();
      test_hold();
      test_spurious_done();
      test_chain();
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end
endmodule